// File: doc/BRIEF.md
# Four-Address I2C Target Controller

This block is the target (slave) side of an I2C-compatible two-wire bus. It can answer to four independently programmed 7-bit addresses. Each address has its own enable. When an address phase matches, the block reports which address was hit as a one-hot code. It acknowledges the address and then either receives bytes for the local host or sends bytes that the host has queued. Both bus lines are seen through a synchroniser and a digital glitch filter. The block drives a line only by pulling it low; the pad logic supplies the open-drain outputs.

The local host side is a plain strobe interface:
- address and enable inputs;
- a transmit byte register loaded by a strobe;
- a received byte with a valid flag that a read strobe clears;
- sticky event flags with a shared interrupt output.

If a new byte completes while the previous one is still unread, the block holds SCL low until the host reads. A programmable bus timeout counts system clocks while SCL is low during this target's transaction. When the limit is reached, the block gives up the transaction and releases both lines.

Top module: `i2c_quad_target`

## Requirements
- R1: A START (SDA falling while SCL is high, after filtering) raises `busy` and `bus_active` and sets `flags[0]`. A STOP (SDA rising while SCL is high) ends any transaction.
- R2: The first eight bits after a START are taken MSB first. Bits 7..1 form the address and bit 0 is the direction (1 = target sends). Each of the four `slave_addr` entries is compared only when its `addr_en` bit is 1.
- R3: A match to entry i reports `match_code` with only bit i set (entry 0 → 1, entry 1 → 2, entry 2 → 4, entry 3 → 8). When several enabled entries match, the lowest index wins. When none match, the code is 0, nothing is acknowledged, and `busy` falls while `bus_active` stays high.
- R4: The block pulls SDA low during the 9th clock after a matched address and after every byte it receives.
- R5: A received byte appears on `rx_data` (first bit = bit 7) with `rx_valid` = 1. A one-cycle `rx_read` clears `rx_valid`.
- R6: If a received byte completes while `rx_valid` is still 1, SCL is held low until `rx_read`. Then the new byte replaces `rx_data` and is acknowledged.
- R7: In a read transfer the byte last loaded with `tx_load` is shifted out MSB first, and `flags[1]` is set after each byte. A master ACK (SDA low on the 9th clock) starts the next byte from the transmit register. A NACK releases SDA and drops `busy` until the next START or STOP.
- R8: After a STOP, `busy` and `bus_active` are 0 and `match_code` is 0.
- R9: While `busy`, system clocks are counted while filtered SCL is low. When the count reaches `timeout_limit` (0 disables the timeout):
  - `flags[2]` is set;
  - SCL and SDA are released;
  - `busy`, `bus_active` and `match_code` clear;
  - `rx_data` and `rx_valid` keep their values.

  A low phase shorter than the limit never sets the flag.
- R10: `flags[2:0]` (bit 0 start, bit 1 byte sent, bit 2 timeout) stay set until the same bit of `flag_clr` is pulsed. `irq` is 1 when any flag is set whose `irq_en` bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_pull | output | 1 | 1 pulls SDA low (ACK or data 0) |
| slave_addr | input | NUM_ADDR×7 | Programmed target addresses, entry i in `slave_addr[i]` |
| addr_en | input | NUM_ADDR | Per-entry compare enable |
| tx_data | input | 8 | Byte to queue for transmission |
| tx_load | input | 1 | Strobe that copies `tx_data` into the transmit register |
| rx_read | input | 1 | Strobe that marks the received byte as read |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte not yet read |
| match_code | output | NUM_ADDR | One-hot code of the matched entry |
| busy | output | 1 | This target is taking part in a transaction |
| bus_active | output | 1 | Bus is between START and STOP |
| timeout_limit | input | TO_W | Timeout length in clocks, 0 = off |
| flag_clr | input | 3 | Per-flag clear strobes |
| irq_en | input | 3 | Per-flag interrupt enables |
| flags | output | 3 | Sticky flags: start, byte sent, timeout |
| irq | output | 1 | Interrupt request |

## Verification
Clock stretching and the bus timeout can act in the same cycle. A stretch keeps SCL low, and a low SCL is exactly what the timeout counts. The bench creates this overlap by leaving one received byte unread and letting a second byte complete, which starts a stretch. The host then stays silent past the limit. The bench checks that the stretch is still held partway through the window. It then checks that when the limit is reached SCL is released, the timeout flag is set, the transaction state is cleared, and the unread byte is still on `rx_data`.

// File: rtl/i2cq_pkg.sv
`timescale 1ns/1ps
package i2cq_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int NUM_FLAGS = 3;

    localparam int FLAG_START  = 0;
    localparam int FLAG_TXDONE = 1;
    localparam int FLAG_TMO    = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_HOLD,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } eng_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] v, input logic b);
        return {v[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/i2cq_line_cond.sv
`timescale 1ns/1ps
module i2cq_line_cond
    import i2cq_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    localparam int SYNC_LEN = 2;

    logic [SYNC_LEN-1:0] scl_s, sda_s;
    logic [FILT_LEN-1:0] scl_h, sda_h;
    logic scl_f, sda_f, scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s <= '1;
            sda_s <= '1;
            scl_h <= '1;
            sda_h <= '1;
            scl_f <= 1'b1;
            sda_f <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_s <= {scl_s[SYNC_LEN-2:0], scl_in};
            sda_s <= {sda_s[SYNC_LEN-2:0], sda_in};
            scl_h <= {scl_h[FILT_LEN-2:0], scl_s[SYNC_LEN-1]};
            sda_h <= {sda_h[FILT_LEN-2:0], sda_s[SYNC_LEN-1]};
            // a level is accepted only after FILT_LEN equal samples
            if (&scl_h)       scl_f <= 1'b1;
            else if (~|scl_h) scl_f <= 1'b0;
            if (&sda_h)       sda_f <= 1'b1;
            else if (~|sda_h) sda_f <= 1'b0;
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.scl      = scl_f;
        ev.sda      = sda_f;
        ev.scl_rise = scl_f & ~scl_p;
        ev.scl_fall = ~scl_f & scl_p;
        ev.start    = scl_f & scl_p & sda_p & ~sda_f;
        ev.stop     = scl_f & scl_p & ~sda_p & sda_f;
    end

endmodule

// File: rtl/i2cq_addr_match.sv
`timescale 1ns/1ps
module i2cq_addr_match #(
    parameter int NUM_ADDR = 4,
    parameter int ADDR_W   = 7
) (
    input  logic [NUM_ADDR-1:0][ADDR_W-1:0] slave_addr,
    input  logic [NUM_ADDR-1:0]             addr_en,
    input  logic [ADDR_W-1:0]               rx_addr,
    output logic [NUM_ADDR-1:0]             hit_onehot
);
    logic [NUM_ADDR-1:0] raw_hit;

    genvar g;
    generate
        for (g = 0; g < NUM_ADDR; g++) begin : g_cmp
            assign raw_hit[g] = addr_en[g] && (slave_addr[g] == rx_addr);
        end
    endgenerate

    // lowest entry wins when several enabled entries carry the same address
    always_comb begin
        hit_onehot = '0;
        for (int i = NUM_ADDR - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                hit_onehot    = '0;
                hit_onehot[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2cq_bus_timeout.sv
`timescale 1ns/1ps
module i2cq_bus_timeout #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            scl_high,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);
    logic [TO_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || !active || scl_high) begin
            low_cnt <= '0;
        end else if (low_cnt != limit) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign expire = active && !scl_high && (limit != '0) && (low_cnt == limit);

    // R9: an expiry always ends the transaction it was counting
    a_r9_expire_ends_txn: assert property (@(posedge clk) disable iff (rst)
        expire |=> !active);

endmodule

// File: rtl/i2cq_byte_engine.sv
`timescale 1ns/1ps
module i2cq_byte_engine
    import i2cq_pkg::*;
#(
    parameter int NUM_ADDR = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  line_ev_t            ev,
    input  logic                expire,
    input  logic [NUM_ADDR-1:0] hit,
    input  logic [BYTE_W-1:0]   tx_data,
    input  logic                tx_load,
    input  logic                rx_read,
    output logic [ADDR_W-1:0]   addr_field,
    output logic                scl_low,
    output logic                sda_low,
    output logic [BYTE_W-1:0]   rx_data,
    output logic                rx_valid,
    output logic [NUM_ADDR-1:0] match_code,
    output logic                busy,
    output logic                bus_active,
    output logic                tx_done_p
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    eng_state_t           st;
    logic [CNT_W-1:0]     bitn;
    logic [BYTE_W-1:0]    shreg;
    logic [BYTE_W-1:0]    txbuf;
    logic [BYTE_W-2:0]    txsh;
    logic                 rw;
    logic                 ackbit;

    assign addr_field = shreg[BYTE_W-1:1];
    assign busy       = (st != ST_IDLE) && (st != ST_IGNORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            bitn       <= '0;
            shreg      <= '0;
            txbuf      <= '0;
            txsh       <= '0;
            rw         <= 1'b0;
            ackbit     <= 1'b1;
            scl_low    <= 1'b0;
            sda_low    <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            match_code <= '0;
            bus_active <= 1'b0;
            tx_done_p  <= 1'b0;
        end else begin
            tx_done_p <= 1'b0;
            if (tx_load) txbuf <= tx_data;
            if (rx_read) rx_valid <= 1'b0;

            if (expire) begin
                st         <= ST_IDLE;
                scl_low    <= 1'b0;
                sda_low    <= 1'b0;
                bus_active <= 1'b0;
                match_code <= '0;
            end else if (ev.start) begin
                st         <= ST_ADDR;
                bitn       <= '0;
                scl_low    <= 1'b0;
                sda_low    <= 1'b0;
                bus_active <= 1'b1;
            end else if (ev.stop) begin
                st         <= ST_IDLE;
                scl_low    <= 1'b0;
                sda_low    <= 1'b0;
                bus_active <= 1'b0;
                match_code <= '0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_RX: begin
                        if (ev.scl_rise) begin
                            shreg <= shift_in(shreg, ev.sda);
                            bitn  <= bitn + 1'b1;
                        end else if (ev.scl_fall && bitn == LAST_BIT) begin
                            if (st == ST_ADDR) begin
                                if (|hit) begin
                                    match_code <= hit;
                                    rw         <= shreg[0];
                                    sda_low    <= 1'b1;
                                    st         <= ST_ADDR_ACK;
                                end else begin
                                    match_code <= '0;
                                    st         <= ST_IGNORE;
                                end
                            end else begin
                                st <= ST_RX_HOLD;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            bitn <= '0;
                            if (rw) begin
                                sda_low <= ~txbuf[BYTE_W-1];
                                txsh    <= txbuf[BYTE_W-2:0];
                                st      <= ST_TX;
                            end else begin
                                sda_low <= 1'b0;
                                st      <= ST_RX;
                            end
                        end
                    end
                    ST_RX_HOLD: begin
                        if (!rx_valid || rx_read) begin
                            rx_data  <= shreg;
                            rx_valid <= 1'b1;
                            sda_low  <= 1'b1;
                            scl_low  <= 1'b0;
                            st       <= ST_RX_ACK;
                        end else if (!ev.scl) begin
                            scl_low <= 1'b1;
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            sda_low <= 1'b0;
                            bitn    <= '0;
                            st      <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            bitn <= bitn + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (bitn == LAST_BIT) begin
                                sda_low   <= 1'b0;
                                tx_done_p <= 1'b1;
                                st        <= ST_TX_ACK;
                            end else begin
                                sda_low <= ~txsh[BYTE_W-2];
                                txsh    <= {txsh[BYTE_W-3:0], 1'b0};
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            ackbit <= ev.sda;
                        end else if (ev.scl_fall) begin
                            if (!ackbit) begin
                                sda_low <= ~txbuf[BYTE_W-1];
                                txsh    <= txbuf[BYTE_W-2:0];
                                bitn    <= '0;
                                st      <= ST_TX;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: reported match is never more than one entry
    a_r3_code_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_code));

    // R1: a START puts the target into a transaction on the next cycle
    a_r1_start_raises: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (busy && bus_active));

    // R8: a STOP leaves nothing of the transaction behind
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!busy && !bus_active && match_code == '0));

    // R6: a stretch ends only by acknowledging the byte or by abandoning the transfer
    a_r6_stretch_ends_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_low) |-> (sda_low || !busy));

    // R9: a timeout frees both lines
    a_r9_timeout_release: assert property (@(posedge clk) disable iff (rst)
        expire |=> (!scl_low && !sda_low && !busy));

endmodule

// File: rtl/i2c_quad_target.sv
`timescale 1ns/1ps
module i2c_quad_target
    import i2cq_pkg::*;
#(
    parameter int NUM_ADDR = 4,
    parameter int TO_W     = 16,
    parameter int FILT_LEN = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            scl_in,
    input  logic                            sda_in,
    output logic                            scl_pull,
    output logic                            sda_pull,
    input  logic [NUM_ADDR-1:0][ADDR_W-1:0] slave_addr,
    input  logic [NUM_ADDR-1:0]             addr_en,
    input  logic [BYTE_W-1:0]               tx_data,
    input  logic                            tx_load,
    input  logic                            rx_read,
    output logic [BYTE_W-1:0]               rx_data,
    output logic                            rx_valid,
    output logic [NUM_ADDR-1:0]             match_code,
    output logic                            busy,
    output logic                            bus_active,
    input  logic [TO_W-1:0]                 timeout_limit,
    input  logic [NUM_FLAGS-1:0]            flag_clr,
    input  logic [NUM_FLAGS-1:0]            irq_en,
    output logic [NUM_FLAGS-1:0]            flags,
    output logic                            irq
);
    line_ev_t               ev;
    logic                   expire;
    logic                   tx_done_p;
    logic [NUM_ADDR-1:0]    hit;
    logic [ADDR_W-1:0]      addr_field;
    logic [NUM_FLAGS-1:0]   flag_set;

    i2cq_line_cond #(.FILT_LEN(FILT_LEN)) u_line (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2cq_addr_match #(.NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W)) u_match (
        .slave_addr (slave_addr),
        .addr_en    (addr_en),
        .rx_addr    (addr_field),
        .hit_onehot (hit)
    );

    i2cq_bus_timeout #(.TO_W(TO_W)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .active   (busy),
        .scl_high (ev.scl),
        .limit    (timeout_limit),
        .expire   (expire)
    );

    i2cq_byte_engine #(.NUM_ADDR(NUM_ADDR)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .expire     (expire),
        .hit        (hit),
        .tx_data    (tx_data),
        .tx_load    (tx_load),
        .rx_read    (rx_read),
        .addr_field (addr_field),
        .scl_low    (scl_pull),
        .sda_low    (sda_pull),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .match_code (match_code),
        .busy       (busy),
        .bus_active (bus_active),
        .tx_done_p  (tx_done_p)
    );

    always_comb begin
        flag_set              = '0;
        flag_set[FLAG_START]  = ev.start;
        flag_set[FLAG_TXDONE] = tx_done_p;
        flag_set[FLAG_TMO]    = expire;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~flag_clr) | flag_set;
    end

    assign irq = |(flags & irq_en);

    // R10: a flag survives until its own clear strobe
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags[FLAG_TMO] && !flag_clr[FLAG_TMO]) |=> flags[FLAG_TMO]);

endmodule

// File: tb/sim_i2c_quad_target.sv
`timescale 1ns/1ps
module sim_i2c_quad_target;
    localparam int NA = 4;
    localparam int TW = 16;
    localparam int Q  = 8;
    localparam int LIMIT = 100;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic scl_m, sda_m;
    logic scl_pull, sda_pull;
    wire  scl_line = scl_m & ~scl_pull;
    wire  sda_line = sda_m & ~sda_pull;

    logic [NA-1:0][6:0] sa;
    logic [NA-1:0] en;
    logic [7:0] tx_data;
    logic tx_load, rx_read;
    logic [7:0] rx_data;
    logic rx_valid;
    logic [NA-1:0] match_code;
    logic busy, bus_active;
    logic [TW-1:0] tlim;
    logic [2:0] flag_clr, irq_en, flags;
    logic irq;

    i2c_quad_target #(.NUM_ADDR(NA), .TO_W(TW), .FILT_LEN(3)) u0 (
        .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull),
        .slave_addr(sa), .addr_en(en), .tx_data(tx_data), .tx_load(tx_load),
        .rx_read(rx_read), .rx_data(rx_data), .rx_valid(rx_valid),
        .match_code(match_code), .busy(busy), .bus_active(bus_active),
        .timeout_limit(tlim), .flag_clr(flag_clr), .irq_en(irq_en),
        .flags(flags), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1;
        while (!scl_line) tick(1);
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1;
        while (!scl_line) tick(1);
        tick(Q / 2);
        b = sda_line;
        tick(Q / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv8(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
    endtask

    task automatic host_read();
        rx_read = 1'b1; tick(1); rx_read = 1'b0; tick(1);
    endtask

    function automatic logic [3:0] exp_code(input logic [6:0] a);
        for (int i = 0; i < NA; i++)
            if (en[i] && sa[i] == a) return 4'(1 << i);
        return 4'd0;
    endfunction

    initial begin
        logic ack;
        logic [7:0] v;
        logic [3:0] ec;
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
        tx_data = '0; tx_load = 0; rx_read = 0;
        flag_clr = '0; irq_en = '0; tlim = TW'(LIMIT);
        sa[0] = 7'h12; sa[1] = 7'h34; sa[2] = 7'h56; sa[3] = 7'h78;
        en = 4'b1011;
        tick(5);
        rst = 1'b0;
        tick(5);

        // reset state
        check("R1 reset busy", busy, 0);
        check("R1 reset bus_active", bus_active, 0);
        check("R3 reset match", match_code, 0);
        check("R5 reset rx_valid", rx_valid, 0);
        check("R10 reset flags", flags, 0);
        check("R10 reset irq", irq, 0);
        check("R4 reset sda_pull", sda_pull, 0);
        check("R6 reset scl_pull", scl_pull, 0);

        // R2 R3 R4 R8: every 7-bit address against entries 0x12,0x34,(0x56 off),0x78
        for (int a = 0; a < 128; a++) begin
            bus_start();
            check("R1 start busy", busy, 1);
            check("R1 start bus_active", bus_active, 1);
            send_byte({7'(a), 1'b0}, ack);
            ec = exp_code(7'(a));
            check($sformatf("R4 ack addr %0h", a), ack, ec != 0);
            check($sformatf("R3 code addr %0h", a), match_code, ec);
            if (ec == 0) check("R3 miss busy low", busy, 0);
            bus_stop();
            check("R8 stop match", match_code, 0);
            check("R8 stop busy", {busy, bus_active}, 0);
        end

        // R3: duplicate address on entries 0 and 3, all enable masks
        sa[3] = 7'h12;
        for (int m = 0; m < 16; m++) begin
            en = 4'(m);
            bus_start();
            send_byte({7'h12, 1'b0}, ack);
            ec = m[0] ? 4'd1 : (m[3] ? 4'd8 : 4'd0);
            check($sformatf("R3 dup code mask %0h", m), match_code, ec);
            check($sformatf("R2 dup ack mask %0h", m), ack, ec != 0);
            bus_stop();
            bus_start();
            send_byte({7'h56, 1'b0}, ack);
            check($sformatf("R2 en2 mask %0h", m), match_code, m[2] ? 4'd4 : 4'd0);
            bus_stop();
        end
        sa[3] = 7'h78;
        en = 4'b1111;
        flag_clr = 3'b111; tick(1); flag_clr = '0; tick(1);
        check("R10 cleared", flags, 0);

        // R5: two written bytes, each read by the host
        irq_en = 3'b001;
        bus_start();
        send_byte({7'h34, 1'b0}, ack);
        check("R3 code entry1", match_code, 4'd2);
        send_byte(8'hC3, ack);
        check("R4 data ack", ack, 1);
        check("R5 rx_valid set", rx_valid, 1);
        check("R5 rx_data", rx_data, 8'hC3);
        host_read();
        check("R5 rx_valid cleared", rx_valid, 0);
        send_byte(8'h5A, ack);
        check("R5 rx_data 2", rx_data, 8'h5A);
        host_read();
        bus_stop();
        check("R10 start flag", flags[0], 1);
        check("R10 irq", irq, 1);
        check("R9 no timeout normal", flags[2], 0);
        flag_clr = 3'b001; tick(1); flag_clr = '0; tick(1);
        check("R10 irq clear", {flags, irq}, 0);

        // R6: unread byte forces a stretch
        bus_start();
        send_byte({7'h78, 1'b0}, ack);
        check("R3 code entry3", match_code, 4'd8);
        send_byte(8'h11, ack);
        fork
            send_byte(8'h22, ack);
            begin
                while (!scl_pull) tick(1);
                tick(30);
                check("R6 holding scl", scl_pull, 1);
                check("R6 old byte kept", rx_data, 8'h11);
                host_read();
            end
        join
        check("R6 ack after read", ack, 1);
        check("R6 new byte", rx_data, 8'h22);
        check("R6 valid", rx_valid, 1);
        host_read();
        bus_stop();

        // R7: read transfer, ACK then NACK
        tx_data = 8'hA5; tx_load = 1; tick(1); tx_load = 0;
        bus_start();
        send_byte({7'h56, 1'b1}, ack);
        check("R4 read addr ack", ack, 1);
        recv8(v);
        check("R7 first byte", v, 8'hA5);
        tick(4);
        check("R7 tx_done flag", flags[1], 1);
        tx_data = 8'h3C; tx_load = 1; tick(1); tx_load = 0;
        put_bit(1'b0);
        recv8(v);
        check("R7 second byte", v, 8'h3C);
        put_bit(1'b1);
        tick(2);
        check("R7 nack sda free", sda_pull, 0);
        check("R7 nack busy", busy, 0);
        bus_stop();

        // R9: stretch with no host read until timeout
        flag_clr = 3'b111; tick(1); flag_clr = '0; tick(1);
        bus_start();
        send_byte({7'h12, 1'b0}, ack);
        send_byte(8'h11, ack);
        fork
            send_byte(8'h22, ack);
            begin
                while (!scl_pull) tick(1);
                tick(LIMIT / 2);
                check("R9 before limit", {scl_pull, flags[2]}, 2'b10);
                tick(LIMIT - LIMIT / 5);
                check("R9 timeout flag", flags[2], 1);
                check("R9 scl released", scl_pull, 0);
                check("R9 state cleared", {busy, bus_active, match_code}, 0);
                check("R9 byte kept", {rx_valid, rx_data}, {1'b1, 8'h11});
            end
        join
        bus_stop();
        irq_en = 3'b100;
        check("R10 timeout irq", irq, 1);
        flag_clr = 3'b100; tick(1); flag_clr = '0; tick(1);
        check("R10 timeout cleared", {flags[2], irq}, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule